// File: doc/BRIEF.md
# Clocked Serial Port with Chip-Select Fault Detection

This block moves 8-bit frames over a clocked serial link, either as the clock-driving end (master) or as the clock-following end (slave). Bits go out MSB first. Incoming data is sampled on the rising serial-clock edge and outgoing data changes on the falling edge, with the clock idling low. In master mode the serial clock is the system clock divided by `2*CLK_DIV`. A completed frame is copied from the receive shifter into a receive holding register, and a "receive full" flag is raised.

The chip-select input is watched in both modes. In master mode a low level means another master is driving the link, which is a conflict. In slave mode a rise of chip-select before all eight bits have arrived means the far end gave up early, which is an incomplete frame. Either event raises a sticky error flag. While that flag is set the port does nothing. Software clears the flag with a read followed by a write of 0, then writes the sequencer-reset bit to bring the bit counter back to idle.

Software reaches the port over a small register bus. A separate read strobe lets a DMA-style engine take the received byte, and an option input decides whether that strobe also clears the full flag.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, both status flags are 0, `sclkOut` is low, and the control register (address 0) reads 0.
- R2: In master mode (address 0 bit 0 = 1), writing a byte to address 2 while idle starts a transfer:
  - `sdo` presents the byte MSB first and changes only on falling edges of `sclkOut`.
  - `sdi` is sampled on each of the 8 rising edges.
  - `sclkOut` is low again when the transfer ends.
  - The received byte can then be read at address 3.
- R3: In slave mode (bit 0 = 0) with `csIn` low, a byte written to address 2 while idle is shifted out on `sdo`, MSB first, on the falling edges of `sclkIn`. The byte sampled on the 8 rising edges is stored, and status (address 1) bit 1 goes to 1.
- R4: A bus read of address 3 clears the full flag (status bit 1).
- R5: A pulse on `dmaRd` clears the full flag when `dmaKeepFlag` is 0 and leaves it set when `dmaKeepFlag` is 1. `dmaData` always shows the held byte.
- R6: Writing 0 to status bit 1 clears the full flag only if status was read with that bit at 1 since the flag was set. Without such a read, writing 0 leaves the flag set. Writing 1 never changes it.
- R7: In master mode, a low level on `csIn` sets the error flag (status bit 0).
- R8: In slave mode, a rise of `csIn` after one to seven bits of a frame sets the error flag. A rise with no bit received does not.
- R9: While the error flag is 1:
  - `sclkOut` does not toggle.
  - No bit is shifted or sampled, and no frame is stored.
  - A write to address 2 is ignored.
- R10: The error flag clears only when status bit 0 is written with 0 after status was read with that bit at 1. A write of 0 without that read leaves it set.
- R11: Writing 1 to control bit 7 returns the bit counter and master clock state to idle, so the next frame takes a full 8 bits. The bit reads back as 0.
- R12: A frame that completes while the full flag is 1 is discarded, and the held byte keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regSel | input | 2 | Register address: 0 control, 1 status, 2 transmit, 3 receive |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (read side effects happen on the strobed edge) |
| regWdata | input | DW | Write data |
| regRdata | output | DW | Read data for `regSel` (combinational) |
| dmaRd | input | 1 | DMA-style read strobe for the held byte |
| dmaKeepFlag | input | 1 | When 1, `dmaRd` does not clear the full flag |
| dmaData | output | DW | Held receive byte |
| sclkIn | input | 1 | Serial clock from the far end (slave mode) |
| csIn | input | 1 | Active-low chip select, monitored in both modes |
| sdi | input | 1 | Serial data in |
| sclkOut | output | 1 | Generated serial clock (master mode) |
| sdo | output | 1 | Serial data out |

## Verification
Register-bus effects are due at the clock edge that samples the strobe:
- Flag clears and arming land on that edge.
- `regRdata` is valid within the strobe's own cycle.
- The bench reads a value one time unit after the falling clock edge on which it raised the strobe.

The serial inputs pass through a two-stage synchroniser plus one edge-detect register. A slave edge therefore takes effect three system clocks after the bench drives it, and a chip-select fault likewise lands three clocks after the pin moves. Every serial half-period in the bench lasts five clocks, so `sdo` and the stored byte are read only after that latency has elapsed. In master mode the bench follows `sclkOut` itself, reading `sdo` at each rising edge and changing `sdi` one falling system-clock edge after each falling serial edge, which is four clocks ahead of the next sample.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TX   = 2'd2;
  localparam logic [1:0] ADDR_RX   = 2'd3;

  localparam int CTRL_MASTER_BIT = 0;
  localparam int CTRL_SEQRST_BIT = 7;
  localparam int STAT_ERR_BIT    = 0;
  localparam int STAT_FULL_BIT   = 1;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic commitRx;
  } strobe_t;
endpackage

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] txIn,
  input  logic          sclkIn,
  input  logic          csIn,
  input  logic          sdi,
  output logic          sclkRise,
  output logic          sclkFall,
  output logic          csHigh,
  output logic          csRise,
  output logic          sdo,
  output logic [DW-1:0] rxData
);
  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, sdiPipe;
  logic sclkLast, csLast, sdiSync;
  logic [DW-1:0] txShift, rxShift, rxNext;

  // multi-stage synchronisers for the asynchronous pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdiPipe  <= '0;
      sclkLast <= 1'b0;
      csLast   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csIn};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      sclkLast <= sclkPipe[SYNC_STAGES-1];
      csLast   <= csPipe[SYNC_STAGES-1];
    end
  end

  assign csHigh   = csPipe[SYNC_STAGES-1];
  assign sdiSync  = sdiPipe[SYNC_STAGES-1];
  assign sclkRise = sclkPipe[SYNC_STAGES-1] && !sclkLast;
  assign sclkFall = !sclkPipe[SYNC_STAGES-1] && sclkLast;
  assign csRise   = csHigh && !csLast;
  assign rxNext   = {rxShift[DW-2:0], sdiSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (stb.loadTx)        txShift <= txIn;
      else if (stb.shiftTx)  txShift <= {txShift[DW-2:0], 1'b0};
      if (stb.sampleRx)      rxShift <= rxNext;
      if (stb.commitRx)      rxData  <= rxNext;
    end
  end

  assign sdo = txShift[DW-1];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DW = 8,
  parameter int CLK_DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regSel,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          dmaRd,
  input  logic          dmaKeepFlag,
  input  logic [DW-1:0] rxData,
  input  logic          sclkRise,
  input  logic          sclkFall,
  input  logic          csHigh,
  input  logic          csRise,
  output strobe_t       stb,
  output logic          sclkOut,
  output logic          busy,
  output logic          rxFull,
  output logic          errFlag
);
  localparam int CNTW = $clog2(DW + 1);
  localparam int DIVW = $clog2(CLK_DIV + 1);
  localparam logic [CNTW-1:0] LAST_IDX = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DW);
  localparam logic [DIVW-1:0] DIV_TOP  = DIVW'(CLK_DIV - 1);

  logic masterMode, sclkReg, rxArm, errArm;
  logic [CNTW-1:0] bitCnt;
  logic [DIVW-1:0] divCnt;
  logic wrCtrl, wrStat, wrTx, rdStat, rdRx, seqRst;
  logic divHit, masterRise, masterFall, slaveRise, slaveFall;
  logic lastBit, startOk, errSet, fullClr, errClr;

  assign wrCtrl = regWr && regSel == ADDR_CTRL;
  assign wrStat = regWr && regSel == ADDR_STAT;
  assign wrTx   = regWr && regSel == ADDR_TX;
  assign rdStat = regRd && regSel == ADDR_STAT;
  assign rdRx   = regRd && regSel == ADDR_RX;
  assign seqRst = wrCtrl && regWdata[CTRL_SEQRST_BIT];

  assign divHit     = masterMode && busy && !errFlag && divCnt == DIV_TOP;
  assign masterRise = divHit && !sclkReg;
  assign masterFall = divHit && sclkReg;
  assign slaveRise  = !masterMode && !csHigh && sclkRise && !errFlag;
  assign slaveFall  = !masterMode && !csHigh && sclkFall && !errFlag && bitCnt != '0;
  assign lastBit    = bitCnt == LAST_IDX;
  assign startOk    = wrTx && !errFlag && !busy && bitCnt == '0;

  always_comb begin
    stb          = '0;
    stb.loadTx   = startOk;
    stb.sampleRx = masterRise || slaveRise;
    stb.commitRx = stb.sampleRx && lastBit && !rxFull;
    stb.shiftTx  = (masterFall && bitCnt != FULL_CNT) || slaveFall;
  end

  assign errSet  = (masterMode && !csHigh) || (!masterMode && csRise && bitCnt != '0);
  assign fullClr = rdRx || (dmaRd && !dmaKeepFlag) ||
                   (wrStat && !regWdata[STAT_FULL_BIT] && rxArm);
  assign errClr  = wrStat && !regWdata[STAT_ERR_BIT] && errArm;

  // bit sequencer and master clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterMode <= 1'b0;
      busy       <= 1'b0;
      sclkReg    <= 1'b0;
      bitCnt     <= '0;
      divCnt     <= '0;
    end else begin
      if (wrCtrl) masterMode <= regWdata[CTRL_MASTER_BIT];
      if (seqRst) begin
        busy    <= 1'b0;
        sclkReg <= 1'b0;
        bitCnt  <= '0;
        divCnt  <= '0;
      end else begin
        if (startOk && masterMode) begin
          busy   <= 1'b1;
          divCnt <= '0;
        end else if (masterMode && busy && !errFlag) begin
          if (divHit) begin
            divCnt  <= '0;
            sclkReg <= !sclkReg;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        if (stb.sampleRx)
          bitCnt <= (!masterMode && lastBit) ? '0 : bitCnt + 1'b1;
        else if (masterFall && bitCnt == FULL_CNT) begin
          busy   <= 1'b0;
          bitCnt <= '0;
        end
      end
    end
  end

  // status flags with read-then-write-0 clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      rxArm   <= 1'b0;
      errFlag <= 1'b0;
      errArm  <= 1'b0;
    end else begin
      if (stb.commitRx) begin
        rxFull <= 1'b1;
        rxArm  <= 1'b0;
      end else if (fullClr) begin
        rxFull <= 1'b0;
        rxArm  <= 1'b0;
      end else if (rdStat && rxFull) begin
        rxArm <= 1'b1;
      end

      if (errSet) begin
        errFlag <= 1'b1;
        if (!errFlag) errArm <= 1'b0;
      end else if (errClr) begin
        errFlag <= 1'b0;
        errArm  <= 1'b0;
      end else if (rdStat && errFlag) begin
        errArm <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      ADDR_CTRL: regRdata[CTRL_MASTER_BIT] = masterMode;
      ADDR_STAT: begin
        regRdata[STAT_FULL_BIT] = rxFull;
        regRdata[STAT_ERR_BIT]  = errFlag;
      end
      ADDR_RX:   regRdata = rxData;
      default:   regRdata = '0;
    endcase
  end

  assign sclkOut = sclkReg;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DW = 8,
  parameter int CLK_DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regSel,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          dmaRd,
  input  logic          dmaKeepFlag,
  output logic [DW-1:0] dmaData,
  input  logic          sclkIn,
  input  logic          csIn,
  input  logic          sdi,
  output logic          sclkOut,
  output logic          sdo
);
  strobe_t stb;
  logic sclkRise, sclkFall, csHigh, csRise;
  logic busy, rxFull, errFlag;
  logic [DW-1:0] rxData;

  ssp_ctrl #(.DW(DW), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .dmaRd(dmaRd),
    .dmaKeepFlag(dmaKeepFlag), .rxData(rxData), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .csHigh(csHigh), .csRise(csRise), .stb(stb),
    .sclkOut(sclkOut), .busy(busy), .rxFull(rxFull), .errFlag(errFlag)
  );

  ssp_datapath #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txIn(regWdata), .sclkIn(sclkIn),
    .csIn(csIn), .sdi(sdi), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csHigh(csHigh), .csRise(csRise), .sdo(sdo), .rxData(rxData)
  );

  assign dmaData = rxData;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    regSel,
  input logic          regWr,
  input logic [DW-1:0] regWdata,
  input logic [DW-1:0] dmaData,
  input logic          sclkOut,
  input logic          busy,
  input logic          rxFull,
  input logic          errFlag
);
  logic errWriteZero, seqWrite;
  assign errWriteZero = regWr && regSel == 2'd1 && !regWdata[0];
  assign seqWrite     = regWr && regSel == 2'd0 && regWdata[7];

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errWriteZero |=> errFlag); // R10
  AST_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |=> errFlag); // R10
  AST_FROZEN_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !seqWrite |=> $stable(sclkOut)); // R9
  AST_FROZEN_RX: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> $stable(dmaData)); // R9
  AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |=> $stable(dmaData)); // R12
  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkOut); // R2
endmodule

bind sync_serial_port ssp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
  .dmaData(dmaData), .sclkOut(sclkOut), .busy(busy), .rxFull(rxFull),
  .errFlag(errFlag)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata, dmaData;
  logic dmaRd = 1'b0, dmaKeepFlag = 1'b0;
  logic sclkIn = 1'b0, csIn = 1'b1, sdi = 1'b0;
  logic sclkOut, sdo;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_serial_port #(.DW(8), .CLK_DIV(DIV)) u_sync_serial_port (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .dmaRd(dmaRd),
    .dmaKeepFlag(dmaKeepFlag), .dmaData(dmaData), .sclkIn(sclkIn),
    .csIn(csIn), .sdi(sdi), .sclkOut(sclkOut), .sdo(sdo)
  );

  function automatic int statusExp(bit full, bit err);
    return (int'(full) << 1) | int'(err);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    regSel = s; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    regSel = s; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic halfWait();
    repeat (5) @(negedge clk);
  endtask

  task automatic masterXfer(logic [7:0] tx, logic [7:0] rx, output logic [7:0] seen);
    sdi = rx[7];
    regWrite(2'd2, tx);
    for (int i = 7; i >= 0; i--) begin
      @(posedge sclkOut);
      seen[i] = sdo;
      @(negedge sclkOut);
      @(negedge clk);
      if (i > 0) sdi = rx[i-1];
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic slaveXfer(logic [7:0] tx, logic [7:0] rx, int nbits,
                           output logic [7:0] seen);
    seen = '0;
    regWrite(2'd2, tx);
    csIn = 1'b0;
    halfWait();
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = rx[i];
      halfWait();
      seen[i] = sdo;
      sclkIn = 1'b1;
      halfWait();
      sclkIn = 1'b0;
      halfWait();
    end
    csIn = 1'b1;
    halfWait();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, seen, tx, rx, keepA;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd1, rd); check("R1 status", rd, statusExp(0, 0));
    regRead(2'd0, rd); check("R1 ctrl", rd, 0);
    check("R1 sclkOut", sclkOut, 0);

    // R3 / R4 random slave frames
    regWrite(2'd0, 8'h00);
    for (int n = 0; n < 6; n++) begin
      tx = 8'($urandom); rx = 8'($urandom);
      slaveXfer(tx, rx, 8, seen);
      check("R3 slave sdo", seen, tx);
      regRead(2'd1, rd); check("R3 full set", rd, statusExp(1, 0));
      regRead(2'd3, rd); check("R3 slave rx", rd, rx);
      regRead(2'd1, rd); check("R4 read clears", rd, statusExp(0, 0));
    end

    // R2 random master frames
    regWrite(2'd0, 8'h01);
    for (int n = 0; n < 6; n++) begin
      tx = 8'($urandom); rx = 8'($urandom);
      masterXfer(tx, rx, seen);
      check("R2 master sdo", seen, tx);
      check("R2 clock idle", sclkOut, 0);
      regRead(2'd3, rd); check("R2 master rx", rd, rx);
      regRead(2'd1, rd); check("R4 read clears", rd, statusExp(0, 0));
    end

    // R5 DMA read with and without the keep option
    masterXfer(8'h3c, 8'ha5, seen);
    check("R5 dmaData", dmaData, 8'ha5);
    @(negedge clk); dmaKeepFlag = 1'b1; dmaRd = 1'b1;
    @(negedge clk); dmaRd = 1'b0;
    regRead(2'd1, rd); check("R5 keep flag", rd, statusExp(1, 0));
    @(negedge clk); dmaKeepFlag = 1'b0; dmaRd = 1'b1;
    @(negedge clk); dmaRd = 1'b0;
    regRead(2'd1, rd); check("R5 dma clears", rd, statusExp(0, 0));

    // R6 write-0 clearing rules for the full flag
    masterXfer(8'h81, 8'h5a, seen);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R6 write0 no read", rd, statusExp(1, 0));
    regWrite(2'd1, 8'hff);
    regRead(2'd1, rd); check("R6 write1", rd, statusExp(1, 0));
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R6 read then write0", rd, statusExp(0, 0));

    // R12 overrun discards the new frame
    keepA = 8'($urandom);
    masterXfer(8'h11, keepA, seen);
    masterXfer(8'h22, ~keepA, seen);
    regRead(2'd3, rd); check("R12 old byte kept", rd, keepA);
    regRead(2'd1, rd); check("R12 cleared after read", rd, statusExp(0, 0));

    // R7 master conflict, R9 freeze, R10 error clearing
    csIn = 1'b0;
    repeat (5) @(negedge clk);
    regRead(2'd1, rd); check("R7 conflict", rd, statusExp(0, 1));
    regWrite(2'd2, 8'hf0);
    begin
      int toggles = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (sclkOut) toggles++;
      end
      check("R9 clock frozen", toggles, 0);
    end
    csIn = 1'b1;
    repeat (5) @(negedge clk);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R10 write0 no read", rd, statusExp(0, 1));
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R10 read then write0", rd, statusExp(0, 0));
    begin
      int toggles = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (sclkOut) toggles++;
      end
      check("R9 tx write ignored", toggles, 0);
    end

    // R8 slave incomplete frame
    regWrite(2'd0, 8'h00);
    csIn = 1'b0; halfWait(); csIn = 1'b1; halfWait();
    regRead(2'd1, rd); check("R8 idle cs rise", rd, statusExp(0, 0));
    slaveXfer(8'hc3, 8'h96, 3, seen);
    regRead(2'd1, rd); check("R8 incomplete", rd, statusExp(0, 1));

    // R9 slave clocks ignored while the error is set
    keepA = dmaData;
    slaveXfer(8'h00, 8'hff, 8, seen);
    check("R9 rx unchanged", dmaData, keepA);
    regRead(2'd1, rd); check("R9 no frame stored", rd, statusExp(0, 1));
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd); check("R10 cleared", rd, statusExp(0, 0));

    // R11 sequencer reset restores a full 8-bit frame
    regWrite(2'd0, 8'h80);
    regRead(2'd0, rd); check("R11 reset bit reads 0", rd, 0);
    tx = 8'($urandom); rx = 8'($urandom);
    slaveXfer(tx, rx, 8, seen);
    check("R11 sdo after reset", seen, tx);
    regRead(2'd3, rd); check("R11 rx after reset", rd, rx);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule